// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Sequencer

This block is the control core of one DMA channel. It holds a table of buffer descriptors. Each entry pairs a byte count with a set of attribute bits. Software fills the table through a simple write port and then starts the channel on a chosen entry and bus. From then on, every request pulse produces one bus transaction on a valid/ready handshake. Each transaction carries:

- a byte size, limited by the descriptor's size code and by the bytes still left in the buffer;
- a read/write direction;
- a 3-bit transfer code;
- the bus select.

When a buffer's count runs out, the attributes decide what happens next. The channel may flush its data FIFO and raise a flush interrupt. It then either follows the chain to a named descriptor on a named bus, or stops and raises a done interrupt. A reserved size code stops the channel and sets a sticky error flag. The `active` output lets software tell, on a flush interrupt, whether the channel is still running. Data movement and addressing are outside this block.

Top module: `dma_bd_seq`

## Requirements
- R1: A cycle with `cfg_we` high writes `cfg_cnt` and `cfg_attr` into entry `cfg_idx`. The attribute layout is:
  - [2:0] size code
  - [3] direction
  - [4] flush
  - [5] transfer-code select
  - [6] chain enable
  - [7] next bus
  - [13:8] next entry
- R2: While idle, a `start` pulse sets `active` and makes entry `start_idx` on bus `start_bus` current, with its full count remaining. A `start` while active is ignored, and a `req` while idle issues nothing.
- R3: Size codes map to maximum sizes as follows: 001 = 1 byte, 010 = 2, 011 = 4, 000 = 8, 100 = one 32-byte burst. Each transaction's `txn_bytes` is the smaller of that maximum and the bytes remaining.
- R4: `txn_rd` equals the direction bit (1 read, 0 write). `txn_tc` is 110 when the transfer-code select is 0 and 111 when it is 1. `txn_bus` is the current bus select (0 local, 1 system), and `txn_bd` is the current entry.
- R5: A `req` seen while active with nothing outstanding raises `txn_valid` on the next cycle. The transaction's fields stay stable until `txn_ready` accepts it, and `txn_valid` drops after acceptance.
- R6: A `req` seen while a transaction is outstanding is held as one pending request. It is issued in the cycle after the acceptance.
- R7: When the remaining count reaches zero with chain enable set, later requests are served from the next-entry field's descriptor, and the bus select is reloaded from the next-bus bit.
- R8: When the count reaches zero with chain enable clear, `active` drops and `irq_done` pulses for one cycle.
- R9: When the count reaches zero with the flush bit set, `fifo_flush` and `irq_flush` pulse for one cycle. With the flush bit clear, neither pulses.
- R10: Starting or chaining into an entry whose size code is 101, 110 or 111 clears `active`, issues no transaction and sets `err`. `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 6 | Descriptor entry to write |
| cfg_cnt | input | 16 | Byte count to store |
| cfg_attr | input | 14 | Attribute bits to store |
| start | input | 1 | Start the channel when idle |
| start_idx | input | 6 | First descriptor entry |
| start_bus | input | 1 | Initial bus select |
| req | input | 1 | Transfer request pulse |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction accepted |
| txn_rd | output | 1 | 1 read, 0 write |
| txn_tc | output | 3 | Transfer code |
| txn_bus | output | 1 | Bus select for the transaction |
| txn_bytes | output | 6 | Bytes in the transaction |
| txn_bd | output | 6 | Descriptor entry serving it |
| fifo_flush | output | 1 | FIFO flush pulse |
| irq_flush | output | 1 | Flush interrupt pulse |
| irq_done | output | 1 | Chain finished pulse |
| active | output | 1 | Channel running |
| err | output | 1 | Sticky reserved-size error |

## Verification
Results fall due at fixed points relative to the stimulus:
- `txn_valid` is due on the cycle after the edge that samples `req`.
- After the edge that samples `txn_valid` with `txn_ready`, `txn_valid` falls. On that same cycle the flush and done pulses, the new `active` and the new `err` appear.
- A held pending request shows up one edge later still.
- The effects of a start appear right after the edge that samples it.

The bench drives inputs on falling edges and samples outputs on the falling edge that follows the edge each result depends on. Expected sizes, codes, entries and bus values come from a model of the descriptor table that the bench keeps itself.

// File: rtl/dma_bd_pkg.sv
package dma_bd_pkg;
  localparam int BD_IDX_W = 6;
  localparam int BD_DEPTH = 1 << BD_IDX_W;

  typedef struct packed {
    logic [BD_IDX_W-1:0] nidx;
    logic                nbus;
    logic                cont;
    logic                tcode;
    logic                flush;
    logic                rd;
    logic [2:0]          tsz;
  } bd_attr_t;

  localparam int ATTR_W = $bits(bd_attr_t);

  function automatic logic tsz_reserved(input logic [2:0] code);
    return code > 3'd4;
  endfunction
endpackage

// File: rtl/dma_bd_table.sv
module dma_bd_table #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16,
  parameter int AW    = 14,
  parameter int NLD   = 2,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IW-1:0]             widx,
  input  logic [CNT_W-1:0]          wcnt,
  input  logic [AW-1:0]             wattr,
  input  logic [IW-1:0]             cur_idx,
  output logic [AW-1:0]             cur_attr,
  input  logic [NLD-1:0][IW-1:0]    ld_idx,
  output logic [NLD-1:0][CNT_W-1:0] ld_cnt,
  output logic [NLD-1:0][2:0]       ld_tsz
);
  logic [CNT_W-1:0] cnt_q  [DEPTH];
  logic [AW-1:0]    attr_q [DEPTH];
  logic [DEPTH-1:0] wen;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign wen[g] = we && (widx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g]  <= '0;
        attr_q[g] <= '0;
      end else if (wen[g]) begin
        cnt_q[g]  <= wcnt;
        attr_q[g] <= wattr;
      end
    end
  end

  assign cur_attr = attr_q[cur_idx];

  for (genvar r = 0; r < NLD; r++) begin : g_ld
    logic [AW-1:0] a;
    assign a         = attr_q[ld_idx[r]];
    assign ld_cnt[r] = cnt_q[ld_idx[r]];
    assign ld_tsz[r] = a[2:0];
  end
endmodule

// File: rtl/dma_bd_sizer.sv
module dma_bd_sizer #(
  parameter int CNT_W       = 16,
  parameter int BURST_BYTES = 32,
  parameter int BYTES_W     = 6
) (
  input  logic [2:0]         tsz,
  input  logic [CNT_W-1:0]   rem,
  output logic [BYTES_W-1:0] bytes
);
  logic [BYTES_W-1:0] cap;

  always_comb begin
    case (tsz)
      3'b001:  cap = BYTES_W'(1);
      3'b010:  cap = BYTES_W'(2);
      3'b011:  cap = BYTES_W'(4);
      3'b000:  cap = BYTES_W'(8);
      3'b100:  cap = BYTES_W'(BURST_BYTES);
      default: cap = '0;
    endcase
    if (rem < CNT_W'(cap)) bytes = rem[BYTES_W-1:0];
    else                   bytes = cap;
  end
endmodule

// File: rtl/dma_bd_ctrl.sv
module dma_bd_ctrl
  import dma_bd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BURST_BYTES = 32,
  parameter int BYTES_W     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [BD_IDX_W-1:0] start_idx,
  input  logic                start_bus,
  input  logic [CNT_W-1:0]    start_cnt,
  input  logic [2:0]          start_tsz,
  input  logic [CNT_W-1:0]    nxt_cnt,
  input  logic [2:0]          nxt_tsz,
  input  bd_attr_t            cur,
  input  logic [BYTES_W-1:0]  size_now,
  output logic [BD_IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0]    rem_o,
  input  logic                req,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic                txn_rd,
  output logic [2:0]          txn_tc,
  output logic                txn_bus,
  output logic [BYTES_W-1:0]  txn_bytes,
  output logic [BD_IDX_W-1:0] txn_bd,
  output logic                fifo_flush,
  output logic                irq_flush,
  output logic                irq_done,
  output logic                active,
  output logic                err
);
  logic                active_q, active_d;
  logic [BD_IDX_W-1:0] idx_q, idx_d;
  logic                bus_q, bus_d;
  logic [CNT_W-1:0]    rem_q, rem_d, rem_left;
  logic                pend_q, pend_d;
  logic                vld_q, vld_d;
  logic [BYTES_W-1:0]  bytes_q, bytes_d;
  logic                rd_q, rd_d;
  logic [2:0]          tc_q, tc_d;
  logic                tbus_q, tbus_d;
  logic [BD_IDX_W-1:0] tbd_q, tbd_d;
  logic                flush_q, flush_d;
  logic                done_q, done_d;
  logic                err_q, err_d;
  logic                issue, accept;

  assign accept   = vld_q && txn_ready;
  assign issue    = active_q && !vld_q && (pend_q || req);
  assign rem_left = rem_q - CNT_W'(bytes_q);

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    bus_d    = bus_q;
    rem_d    = rem_q;
    pend_d   = pend_q;
    vld_d    = vld_q;
    bytes_d  = bytes_q;
    rd_d     = rd_q;
    tc_d     = tc_q;
    tbus_d   = tbus_q;
    tbd_d    = tbd_q;
    err_d    = err_q;
    flush_d  = 1'b0;
    done_d   = 1'b0;
    if (!active_q) begin
      pend_d = 1'b0;
      if (start) begin
        if (tsz_reserved(start_tsz)) begin
          err_d = 1'b1;
        end else begin
          active_d = 1'b1;
          idx_d    = start_idx;
          bus_d    = start_bus;
          rem_d    = start_cnt;
        end
      end
    end else begin
      if (issue) begin
        vld_d   = 1'b1;
        bytes_d = size_now;
        rd_d    = cur.rd;
        tc_d    = {2'b11, cur.tcode};
        tbus_d  = bus_q;
        tbd_d   = idx_q;
        pend_d  = 1'b0;
      end else if (req) begin
        pend_d = 1'b1;
      end
      if (accept) begin
        vld_d = 1'b0;
        rem_d = rem_left;
        if (rem_left == '0) begin
          flush_d = cur.flush;
          if (cur.cont) begin
            if (tsz_reserved(nxt_tsz)) begin
              err_d    = 1'b1;
              active_d = 1'b0;
              pend_d   = 1'b0;
            end else begin
              idx_d = cur.nidx;
              bus_d = cur.nbus;
              rem_d = nxt_cnt;
            end
          end else begin
            active_d = 1'b0;
            done_d   = 1'b1;
            pend_d   = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      bus_q    <= 1'b0;
      rem_q    <= '0;
      pend_q   <= 1'b0;
      vld_q    <= 1'b0;
      bytes_q  <= '0;
      rd_q     <= 1'b0;
      tc_q     <= 3'b110;
      tbus_q   <= 1'b0;
      tbd_q    <= '0;
      flush_q  <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      bus_q    <= bus_d;
      rem_q    <= rem_d;
      pend_q   <= pend_d;
      vld_q    <= vld_d;
      bytes_q  <= bytes_d;
      rd_q     <= rd_d;
      tc_q     <= tc_d;
      tbus_q   <= tbus_d;
      tbd_q    <= tbd_d;
      flush_q  <= flush_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign idx_o      = idx_q;
  assign rem_o      = rem_q;
  assign txn_valid  = vld_q;
  assign txn_rd     = rd_q;
  assign txn_tc     = tc_q;
  assign txn_bus    = tbus_q;
  assign txn_bytes  = bytes_q;
  assign txn_bd     = tbd_q;
  assign fifo_flush = flush_q;
  assign irq_flush  = flush_q;
  assign irq_done   = done_q;
  assign active     = active_q;
  assign err        = err_q;

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !vld_q);
  assert_size_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (bytes_q <= BYTES_W'(BURST_BYTES)) && (CNT_W'(bytes_q) <= rem_q));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !txn_ready |=> vld_q && $stable(bytes_q) && $stable(tbd_q) && $stable(tc_q));
  assert_done_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !active_q && !vld_q);
  assert_flush_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_q) |-> $past(accept));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/dma_bd_seq.sv
module dma_bd_seq
  import dma_bd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BURST_BYTES = 32,
  localparam int BYTES_W    = $clog2(BURST_BYTES) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [BD_IDX_W-1:0] cfg_idx,
  input  logic [CNT_W-1:0]    cfg_cnt,
  input  logic [ATTR_W-1:0]   cfg_attr,
  input  logic                start,
  input  logic [BD_IDX_W-1:0] start_idx,
  input  logic                start_bus,
  input  logic                req,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic                txn_rd,
  output logic [2:0]          txn_tc,
  output logic                txn_bus,
  output logic [BYTES_W-1:0]  txn_bytes,
  output logic [BD_IDX_W-1:0] txn_bd,
  output logic                fifo_flush,
  output logic                irq_flush,
  output logic                irq_done,
  output logic                active,
  output logic                err
);
  localparam int NLD = 2;

  logic [BD_IDX_W-1:0]          cur_idx;
  logic [ATTR_W-1:0]            cur_raw;
  bd_attr_t                     cur;
  logic [NLD-1:0][BD_IDX_W-1:0] ld_idx;
  logic [NLD-1:0][CNT_W-1:0]    ld_cnt;
  logic [NLD-1:0][2:0]          ld_tsz;
  logic [CNT_W-1:0]             rem;
  logic [BYTES_W-1:0]           size_now;

  assign cur       = bd_attr_t'(cur_raw);
  assign ld_idx[0] = start_idx;
  assign ld_idx[1] = cur.nidx;

  dma_bd_table #(
    .DEPTH(BD_DEPTH), .CNT_W(CNT_W), .AW(ATTR_W), .NLD(NLD)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_we), .widx(cfg_idx), .wcnt(cfg_cnt), .wattr(cfg_attr),
    .cur_idx(cur_idx), .cur_attr(cur_raw),
    .ld_idx(ld_idx), .ld_cnt(ld_cnt), .ld_tsz(ld_tsz)
  );

  dma_bd_sizer #(
    .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES), .BYTES_W(BYTES_W)
  ) u_sizer (
    .tsz(cur.tsz), .rem(rem), .bytes(size_now)
  );

  dma_bd_ctrl #(
    .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES), .BYTES_W(BYTES_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_idx(start_idx), .start_bus(start_bus),
    .start_cnt(ld_cnt[0]), .start_tsz(ld_tsz[0]),
    .nxt_cnt(ld_cnt[1]), .nxt_tsz(ld_tsz[1]),
    .cur(cur), .size_now(size_now),
    .idx_o(cur_idx), .rem_o(rem),
    .req(req), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_rd(txn_rd), .txn_tc(txn_tc), .txn_bus(txn_bus),
    .txn_bytes(txn_bytes), .txn_bd(txn_bd),
    .fifo_flush(fifo_flush), .irq_flush(irq_flush), .irq_done(irq_done),
    .active(active), .err(err)
  );
endmodule

// File: tb/sim_dma_bd_seq.sv
module sim_dma_bd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [15:0] cfg_cnt = '0;
  logic [13:0] cfg_attr = '0;
  logic        start = 1'b0;
  logic [5:0]  start_idx = '0;
  logic        start_bus = 1'b0;
  logic        req = 1'b0;
  logic        txn_ready = 1'b0;
  logic        txn_valid, txn_rd, txn_bus, fifo_flush, irq_flush, irq_done, active, err;
  logic [2:0]  txn_tc;
  logic [5:0]  txn_bytes, txn_bd;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [15:0] m_cnt  [64];
  logic [13:0] m_attr [64];
  logic [5:0]  m_idx;
  logic        m_bus;
  int          m_rem;
  bit          m_active = 1'b0;
  bit          m_err = 1'b0;

  always #4 clk = ~clk;

  dma_bd_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_cnt(cfg_cnt), .cfg_attr(cfg_attr), .start(start),
    .start_idx(start_idx), .start_bus(start_bus), .req(req),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_rd(txn_rd),
    .txn_tc(txn_tc), .txn_bus(txn_bus), .txn_bytes(txn_bytes),
    .txn_bd(txn_bd), .fifo_flush(fifo_flush), .irq_flush(irq_flush),
    .irq_done(irq_done), .active(active), .err(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input int tsz, input bit rd, input bit fl,
                                     input bit tc, input bit cont, input bit nbus,
                                     input int nidx);
    return {nidx[5:0], nbus, cont, tc, fl, rd, tsz[2:0]};
  endfunction

  function automatic int max_bytes(input logic [2:0] code);
    case (code)
      3'b001: return 1;
      3'b010: return 2;
      3'b011: return 4;
      3'b000: return 8;
      3'b100: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic bit rsvd(input logic [2:0] code);
    return code >= 3'd5;
  endfunction

  task automatic wr(input int idx, input int cnt, input logic [13:0] attr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[5:0]; cfg_cnt = cnt[15:0]; cfg_attr = attr;
    @(negedge clk);
    cfg_we = 1'b0;
    m_cnt[idx] = cnt[15:0];
    m_attr[idx] = attr;
  endtask

  task automatic do_start(input int idx, input bit bus);
    @(negedge clk);
    start = 1'b1; start_idx = idx[5:0]; start_bus = bus;
    @(negedge clk);
    start = 1'b0;
    if (!m_active) begin
      if (rsvd(m_attr[idx][2:0])) m_err = 1'b1;
      else begin
        m_active = 1'b1; m_idx = idx[5:0]; m_bus = bus; m_rem = m_cnt[idx];
      end
    end
    chk("R2 active after start", active, m_active);
    chk("R10 err after start", err, m_err);
    chk("R10 no txn after start", txn_valid, 0);
  endtask

  // one request, held dly cycles, then accepted; all fields checked
  task automatic serve(input int dly);
    logic [13:0] a;
    int eb;
    bit ends;
    a = m_attr[m_idx];
    eb = (m_rem < max_bytes(a[2:0])) ? m_rem : max_bytes(a[2:0]);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk("R5 valid one cycle after req", txn_valid, 1);
    chk("R3 bytes", txn_bytes, eb);
    chk("R4 direction", txn_rd, a[3]);
    chk("R4 transfer code", txn_tc, a[5] ? 7 : 6);
    chk("R4 bus", txn_bus, m_bus);
    chk("R7 entry", txn_bd, m_idx);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk("R5 valid held", txn_valid, 1);
      chk("R5 bytes stable", txn_bytes, eb);
    end
    txn_ready = 1'b1;
    @(negedge clk); txn_ready = 1'b0;
    chk("R5 valid drops after accept", txn_valid, 0);
    m_rem = m_rem - eb;
    ends = (m_rem == 0);
    if (ends) begin
      if (a[6]) begin
        if (rsvd(m_attr[a[13:8]][2:0])) begin
          m_err = 1'b1; m_active = 1'b0;
        end else begin
          m_idx = a[13:8]; m_bus = a[7]; m_rem = m_cnt[a[13:8]];
        end
      end else m_active = 1'b0;
    end
    chk("R9 fifo_flush", fifo_flush, ends && a[4]);
    chk("R9 irq_flush", irq_flush, ends && a[4]);
    chk("R8 irq_done", irq_done, ends && !a[6]);
    chk("R8 active", active, m_active);
    chk("R10 err", err, m_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) begin m_cnt[i] = '0; m_attr[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset active", active, 0);
    chk("R5 reset valid", txn_valid, 0);
    chk("R10 reset err", err, 0);

    // R2: request while idle issues nothing
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk("R2 idle req ignored", txn_valid, 0);
    @(negedge clk);
    chk("R2 idle req ignored later", txn_valid, 0);

    // R1 R3 R6: pending request behind an outstanding one
    wr(10, 16, mk(0, 1, 0, 0, 0, 0, 0));
    do_start(10, 1'b0);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk("R5 first issue", txn_valid, 1);
    chk("R3 first size", txn_bytes, 8);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk("R6 still one outstanding", txn_valid, 1);
    txn_ready = 1'b1;
    @(negedge clk); txn_ready = 1'b0;
    chk("R6 drop after accept", txn_valid, 0);
    @(negedge clk);
    chk("R6 pending issued", txn_valid, 1);
    chk("R6 pending size", txn_bytes, 8);
    txn_ready = 1'b1;
    @(negedge clk); txn_ready = 1'b0;
    chk("R8 done pulse", irq_done, 1);
    chk("R8 inactive", active, 0);
    @(negedge clk);
    chk("R8 done one cycle", irq_done, 0);
    m_active = 1'b0;

    // R2: start while active ignored; R3 burst sizes 32,32,6
    wr(20, 70, mk(4, 0, 0, 1, 0, 0, 0));
    wr(21, 5, mk(1, 1, 0, 0, 0, 1, 0));
    do_start(20, 1'b1);
    do_start(21, 1'b0);
    serve(0); serve(2); serve(1);

    // R7 R9: flush at chain to another bus and entry
    wr(30, 8, mk(3, 0, 1, 0, 1, 1, 31));
    wr(31, 3, mk(1, 1, 0, 1, 0, 0, 0));
    do_start(30, 1'b0);
    serve(0); serve(0);
    @(negedge clk);
    chk("R9 flush one cycle", irq_flush, 0);
    serve(1); serve(0); serve(0);

    // random descriptor tables and chains
    for (int run = 0; run < 6; run++) begin
      for (int i = 0; i < 64; i++)
        wr(i, 1 + ($urandom % 90),
           mk($urandom % 5, $urandom % 2, $urandom % 2, $urandom % 2,
              ($urandom % 4) != 0, $urandom % 2, $urandom % 64));
      do_start($urandom % 64, $urandom % 2);
      for (int n = 0; n < 60 && m_active; n++) serve($urandom % 3);
      if (m_active) begin
        // drain: stop the chain at the current entry
        wr(m_idx, m_cnt[m_idx], {m_attr[m_idx][13:7], 1'b0, m_attr[m_idx][5:0]});
        for (int n = 0; n < 200 && m_active; n++) serve(0);
      end
    end

    // R10: reserved size at start, then via chain
    wr(40, 4, mk(5, 0, 0, 0, 0, 0, 0));
    do_start(40, 1'b0);
    chk("R10 err from start", err, 1);
    wr(41, 2, mk(2, 0, 0, 0, 1, 0, 42));
    wr(42, 4, mk(6, 0, 0, 0, 0, 0, 0));
    do_start(41, 1'b0);
    serve(0);
    chk("R10 chain stop", active, 0);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk("R10 no txn after error", txn_valid, 0);
    chk("R10 sticky", err, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule